// File: doc/BRIEF.md
# Trigger-Address Processor Core

This block is a minimal processor whose instruction stream holds no opcodes. Each program word is a 6-bit target address, and executing a word means triggering whatever sits at that address in one shared address space. A handful of slots in that space are arithmetic and transfer devices acting on two internal 8-bit registers, an accumulator and an operand register. A 32-word data memory fills the upper half of the space, where a trigger stores the accumulator. The single operation is therefore the same for every word. Only the address decode decides what happens.

The core fetches from an external program ROM through an address/data port and expects the word back in the same cycle. It executes exactly one word per clock, and its program counter simply steps forward. The all-ones word stops the machine. Branching, interrupts and pipelining are not part of the block.

Top module: `tta_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, operand register and done flag to zero. Reset also clears the data memory.
- R2: While not halted, the program counter (`prog_addr`) advances by one on every clock and wraps from 63 to 0. One program word executes per clock.
- R3: Word 20 (add slot) sets the accumulator to accumulator + operand register, modulo 256.
- R4: Word 21 (subtract slot) sets the accumulator to accumulator − operand register, modulo 256.
- R5: Word 22 (increment slot) sets the accumulator to accumulator + 1, modulo 256.
- R6: Word 23 (copy slot) loads the operand register with the accumulator. The accumulator is left unchanged.
- R7: Word 30 (read slot) loads the accumulator with the data word whose address is held in the operand register, when that value lies in 32..63. For any other operand value it loads 0.
- R8: Words 32..62 store the accumulator into the data word at that address. The accumulator and operand register are left unchanged.
- R9: Words with no device attached (0..19, 24..29, 31) change neither register.
- R10: Word 63 (all ones) halts the machine. From the next clock on, `done` is 1, the program counter holds the halting word's address, and the registers and memory stay unchanged until reset. The halt takes priority over the data-memory write that address 63 would otherwise mean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| prog_addr | output | 6 | Program counter, address into the program ROM |
| prog_word | input | 6 | Program word returned by the ROM for `prog_addr`, same cycle |
| acc | output | 8 | Accumulator |
| opr | output | 8 | Operand register |
| done | output | 1 | High once the halt word has executed |

## Verification
The halt code shares its address with the topmost data-memory word, so a single fetch of 63 decodes to both a stop and a store. The bench drives the all-ones word after a long run of arithmetic and again as the very first word after reset. In each case it judges that `done` rises one clock later and that the program counter freezes on the halting word. It also checks that the accumulator and operand register keep their values over several further clocks. A bound property separately requires that the data-memory write strobe stays low whenever the fetched word is all ones.

// File: rtl/tta_pkg.sv
`timescale 1ns/1ps
package tta_pkg;

    // device chosen by decoding a trigger address
    typedef enum logic [2:0] {
        DEV_NONE  = 3'd0,
        DEV_ADD   = 3'd1,
        DEV_SUB   = 3'd2,
        DEV_INC   = 3'd3,
        DEV_COPY  = 3'd4,
        DEV_READ  = 3'd5,
        DEV_WRITE = 3'd6,
        DEV_HALT  = 3'd7
    } dev_e;

    // default trigger slots
    localparam int SLOT_ADD  = 20;
    localparam int SLOT_SUB  = 21;
    localparam int SLOT_INC  = 22;
    localparam int SLOT_COPY = 23;
    localparam int SLOT_READ = 30;
    localparam int DMEM_BASE = 32;
    localparam int DMEM_WORDS = 32;

endpackage

// File: rtl/tta_decode.sv
`timescale 1ns/1ps
module tta_decode
    import tta_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int ADD_AT    = SLOT_ADD,
    parameter int SUB_AT    = SLOT_SUB,
    parameter int INC_AT    = SLOT_INC,
    parameter int COPY_AT   = SLOT_COPY,
    parameter int READ_AT   = SLOT_READ,
    parameter int MEM_BASE  = DMEM_BASE,
    parameter int MEM_DEPTH = DMEM_WORDS,
    localparam int IDX_W    = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output dev_e              dev,
    output logic [IDX_W-1:0]  mem_idx
);

    localparam logic [ADDR_W:0] MEM_LO = (ADDR_W+1)'(MEM_BASE);
    localparam logic [ADDR_W:0] MEM_HI = (ADDR_W+1)'(MEM_BASE + MEM_DEPTH);

    logic [ADDR_W:0] addr_ext;
    assign addr_ext = {1'b0, addr};

    // halt is tested first so it wins over any window it overlaps
    always_comb begin
        dev     = DEV_NONE;
        mem_idx = '0;
        if (&addr) begin
            dev = DEV_HALT;
        end else if (addr == ADDR_W'(ADD_AT)) begin
            dev = DEV_ADD;
        end else if (addr == ADDR_W'(SUB_AT)) begin
            dev = DEV_SUB;
        end else if (addr == ADDR_W'(INC_AT)) begin
            dev = DEV_INC;
        end else if (addr == ADDR_W'(COPY_AT)) begin
            dev = DEV_COPY;
        end else if (addr == ADDR_W'(READ_AT)) begin
            dev = DEV_READ;
        end else if (addr_ext >= MEM_LO && addr_ext < MEM_HI) begin
            dev     = DEV_WRITE;
            mem_idx = IDX_W'(addr - ADDR_W'(MEM_BASE));
        end
    end

endmodule

// File: rtl/tta_alu.sv
`timescale 1ns/1ps
module tta_alu
    import tta_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  dev_e              dev,
    input  logic [DATA_W-1:0] acc_q,
    input  logic [DATA_W-1:0] opr_q,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] acc_d,
    output logic [DATA_W-1:0] opr_d
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // every result is DATA_W wide, so sums wrap modulo 2**DATA_W
    always_comb begin
        acc_d = acc_q;
        opr_d = opr_q;
        unique case (dev)
            DEV_ADD:  acc_d = acc_q + opr_q;
            DEV_SUB:  acc_d = acc_q - opr_q;
            DEV_INC:  acc_d = acc_q + ONE;
            DEV_COPY: opr_d = acc_q;
            DEV_READ: acc_d = rd_data;
            default:  ;
        endcase
    end

endmodule

// File: rtl/tta_dmem.sv
`timescale 1ns/1ps
module tta_dmem #(
    parameter int DATA_W = 8,
    parameter int BASE   = 32,
    parameter int DEPTH  = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rd_ptr,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [DATA_W:0] RD_LO = (DATA_W+1)'(BASE);
    localparam logic [DATA_W:0] RD_HI = (DATA_W+1)'(BASE + DEPTH);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    // next value of each word: its own write strobe
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_comb begin
            mem_d[g] = mem_q[g];
            if (we && widx == IDX_W'(g)) begin
                mem_d[g] = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    // read port addressed by a full data-space pointer
    logic              rd_hit;
    logic [IDX_W-1:0]  rd_idx;

    always_comb begin
        rd_hit  = ({1'b0, rd_ptr} >= RD_LO) && ({1'b0, rd_ptr} < RD_HI);
        rd_idx  = IDX_W'(rd_ptr - DATA_W'(BASE));
        rd_data = rd_hit ? mem_q[rd_idx] : '0;
    end

    // a strobed word holds the written data one clock later
    assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
        we |=> mem_q[$past(widx)] == $past(wdata))
        else $error("data word did not take the written value");

endmodule

// File: rtl/tta_core.sv
`timescale 1ns/1ps
module tta_core
    import tta_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 6,
    parameter int MEM_BASE  = DMEM_BASE,
    parameter int MEM_DEPTH = DMEM_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] prog_addr,
    input  logic [ADDR_W-1:0] prog_word,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] opr,
    output logic              done
);

    localparam int IDX_W = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] HALT_W = '1;
    localparam logic [ADDR_W:0] DW_LO = (ADDR_W+1)'(MEM_BASE);
    localparam logic [ADDR_W:0] DW_HI = (ADDR_W+1)'(MEM_BASE + MEM_DEPTH);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] opr;
        logic              done;
    } core_st_t;

    core_st_t st_q, st_d;

    dev_e              dev;
    logic [IDX_W-1:0]  mem_idx;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] alu_acc, alu_opr;
    logic              mem_we;

    tta_decode #(
        .ADDR_W    (ADDR_W),
        .MEM_BASE  (MEM_BASE),
        .MEM_DEPTH (MEM_DEPTH)
    ) u_decode (
        .addr    (prog_word),
        .dev     (dev),
        .mem_idx (mem_idx)
    );

    tta_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .dev     (dev),
        .acc_q   (st_q.acc),
        .opr_q   (st_q.opr),
        .rd_data (rd_data),
        .acc_d   (alu_acc),
        .opr_d   (alu_opr)
    );

    tta_dmem #(
        .DATA_W (DATA_W),
        .BASE   (MEM_BASE),
        .DEPTH  (MEM_DEPTH)
    ) u_dmem (
        .clk     (clk),
        .rst     (rst),
        .we      (mem_we),
        .widx    (mem_idx),
        .wdata   (st_q.acc),
        .rd_ptr  (st_q.opr),
        .rd_data (rd_data)
    );

    // next state of the core
    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        if (!st_q.done) begin
            if (dev == DEV_HALT) begin
                st_d.done = 1'b1;
            end else begin
                st_d.pc  = st_q.pc + PC_ONE;
                st_d.acc = alu_acc;
                st_d.opr = alu_opr;
                mem_we   = (dev == DEV_WRITE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prog_addr = st_q.pc;
    assign acc       = st_q.acc;
    assign opr       = st_q.opr;
    assign done      = st_q.done;

    // ---------------- assertions ----------------
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!done && prog_word != HALT_W) |=> prog_addr == ADDR_W'($past(prog_addr) + PC_ONE))
        else $error("program counter did not step");

    assert_add_R3: assert property (@(posedge clk) disable iff (rst)
        (!done && prog_word == ADDR_W'(SLOT_ADD)) |=> acc == DATA_W'($past(acc) + $past(opr)))
        else $error("add slot result wrong");

    assert_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (!done && prog_word == ADDR_W'(SLOT_COPY)) |=> (opr == $past(acc)) && $stable(acc))
        else $error("copy slot result wrong");

    assert_read_outside_R7: assert property (@(posedge clk) disable iff (rst)
        (!done && prog_word == ADDR_W'(SLOT_READ) && (opr < DATA_W'(MEM_BASE))) |=> acc == '0)
        else $error("read below the data window returned nonzero");

    assert_write_keeps_regs_R8: assert property (@(posedge clk) disable iff (rst)
        (!done && {1'b0, prog_word} >= DW_LO && {1'b0, prog_word} < DW_HI && prog_word != HALT_W)
        |=> $stable(acc) && $stable(opr))
        else $error("data write disturbed a register");

    assert_halt_rise_R10: assert property (@(posedge clk) disable iff (rst)
        (!done && prog_word == HALT_W) |=> done && $stable(prog_addr) && $stable(acc) && $stable(opr))
        else $error("halt word did not stop the core");

    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> done && $stable(prog_addr) && $stable(acc) && $stable(opr))
        else $error("halted core changed state");

    assert_halt_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        (prog_word == HALT_W) |-> !mem_we)
        else $error("halt word strobed a data write");

endmodule

// File: tb/tb_tta_core.sv
`timescale 1ns/1ps
module tb_tta_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] prog_addr;
    logic [5:0] prog_word;
    logic [7:0] acc;
    logic [7:0] opr;
    logic       done;

    logic [5:0] rom [64];
    assign prog_word = rom[prog_addr];

    always #2 clk = ~clk;   // 250 MHz

    tta_core dut (
        .clk       (clk),
        .rst       (rst),
        .prog_addr (prog_addr),
        .prog_word (prog_word),
        .acc       (acc),
        .opr       (opr),
        .done      (done)
    );

    int  n_vec  = 0;
    int  n_bad  = 0;
    bit  finished = 1'b0;

    // {req[3:0], word[5:0], acc after, opr after, done after}
    localparam int NV = 30;
    localparam logic [26:0] VEC [NV] = '{
        {4'd5,  6'd22, 8'd1,   8'd0,  1'b0},  // R5 inc
        {4'd5,  6'd22, 8'd2,   8'd0,  1'b0},  // R5
        {4'd6,  6'd23, 8'd2,   8'd2,  1'b0},  // R6 copy
        {4'd3,  6'd20, 8'd4,   8'd2,  1'b0},  // R3 add
        {4'd6,  6'd23, 8'd4,   8'd4,  1'b0},  // R6
        {4'd3,  6'd20, 8'd8,   8'd4,  1'b0},  // R3
        {4'd6,  6'd23, 8'd8,   8'd8,  1'b0},  // R6
        {4'd3,  6'd20, 8'd16,  8'd8,  1'b0},  // R3
        {4'd6,  6'd23, 8'd16,  8'd16, 1'b0},  // R6
        {4'd3,  6'd20, 8'd32,  8'd16, 1'b0},  // R3
        {4'd6,  6'd23, 8'd32,  8'd32, 1'b0},  // R6
        {4'd3,  6'd20, 8'd64,  8'd32, 1'b0},  // R3
        {4'd8,  6'd32, 8'd64,  8'd32, 1'b0},  // R8 store 64 at 32
        {4'd9,  6'd5,  8'd64,  8'd32, 1'b0},  // R9 empty slot
        {4'd4,  6'd21, 8'd32,  8'd32, 1'b0},  // R4 sub
        {4'd4,  6'd21, 8'd0,   8'd32, 1'b0},  // R4
        {4'd4,  6'd21, 8'd224, 8'd32, 1'b0},  // R4 wraps below zero
        {4'd8,  6'd33, 8'd224, 8'd32, 1'b0},  // R8 store 224 at 33
        {4'd7,  6'd30, 8'd64,  8'd32, 1'b0},  // R7 read word 32
        {4'd9,  6'd24, 8'd64,  8'd32, 1'b0},  // R9
        {4'd5,  6'd22, 8'd65,  8'd32, 1'b0},  // R5
        {4'd6,  6'd23, 8'd65,  8'd65, 1'b0},  // R6
        {4'd7,  6'd30, 8'd0,   8'd65, 1'b0},  // R7 pointer above window
        {4'd3,  6'd20, 8'd65,  8'd65, 1'b0},  // R3
        {4'd3,  6'd20, 8'd130, 8'd65, 1'b0},  // R3
        {4'd3,  6'd20, 8'd195, 8'd65, 1'b0},  // R3
        {4'd3,  6'd20, 8'd4,   8'd65, 1'b0},  // R3 wraps past 255
        {4'd9,  6'd31, 8'd4,   8'd65, 1'b0},  // R9
        {4'd8,  6'd47, 8'd4,   8'd65, 1'b0},  // R8
        {4'd10, 6'd63, 8'd4,   8'd65, 1'b1}   // R10 halt
    };

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic chk_state(input string req, input int pa, input int a, input int o, input int d);
        chk(req, "prog_addr", int'(prog_addr), pa);
        chk(req, "acc", int'(acc), a);
        chk(req, "opr", int'(opr), o);
        chk(req, "done", int'(done), d);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < 64; i++) rom[i] = 6'd5;
        for (int i = 0; i < NV; i++) rom[i] = VEC[i][22:17];

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_state("R1", 0, 0, 0, 0);
        rst = 1'b0;

        // table walk, one word per clock; R2 via prog_addr
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R%0d", int'(VEC[i][26:23])), "acc", int'(acc), int'(VEC[i][16:9]));
            chk($sformatf("R%0d", int'(VEC[i][26:23])), "opr", int'(opr), int'(VEC[i][8:1]));
            chk($sformatf("R%0d", int'(VEC[i][26:23])), "done", int'(done), int'(VEC[i][0]));
            chk("R2", "prog_addr", int'(prog_addr), (i == NV-1) ? i : i + 1);
        end

        // R10: halted core holds everything
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk_state("R10", 29, 4, 65, 1);

        // R1: reset out of a halt clears the core
        do_reset();
        chk_state("R1", 0, 0, 0, 0);

        // R2 and R5: counter wrap with increments everywhere
        rst = 1'b1;
        for (int i = 0; i < 64; i++) rom[i] = 6'd22;
        @(negedge clk) rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_state("R2", 1, 1, 0, 0);
        repeat (62) @(posedge clk);
        @(negedge clk);
        chk_state("R2", 63, 63, 0, 0);
        @(posedge clk);
        @(negedge clk);
        chk_state("R2", 0, 64, 0, 0);
        @(posedge clk);
        @(negedge clk);
        chk_state("R5", 1, 65, 0, 0);

        // R10: halt as the very first word
        rst = 1'b1;
        rom[0] = 6'd63;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_state("R1", 0, 0, 0, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_state("R10", 0, 0, 0, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_state("R10", 0, 0, 0, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule